// File: doc/BRIEF.md
# Two-read one-write register file with write-first bypass

This block holds the integer architectural registers of a five-stage pipeline. The decode stage reads two source operands through two combinational read ports. The writeback stage retires one result per clock through a synchronous write port. A read, a second read and a write can all occur in the same cycle without conflict.

When a register is written in the same cycle that decode reads it, the read port returns the incoming value instead of the stored one. The write therefore appears to happen before the read within that cycle. Each read port applies this bypass on its own. Register zero is hardwired: it always reads as zero, and writes aimed at it have no effect, in storage or through the bypass.

Top module: `regfile_2r1w`

## Requirements
- R1: While rst_ni is low, and after it is released, every register reads as zero until it is written. The reset is asynchronous.
- R2: With we_i high and waddr_i nonzero, wdata_i is stored on the rising clock edge and returned by either read port in later cycles.
- R3: With we_i low, no register changes at the clock edge.
- R4: A read of address 0 on either port returns 0 in every cycle.
- R5: A write to address 0 is ignored. It does not change later reads, and a same-cycle read of address 0 still returns 0 rather than wdata_i.
- R6: When we_i is high, waddr_i is nonzero and raddr_a_i equals waddr_i, rdata_a_o equals wdata_i in that same cycle.
- R7: When we_i is high, waddr_i is nonzero and raddr_b_i equals waddr_i, rdata_b_o equals wdata_i in that same cycle.
- R8: The two read ports are independent. Each returns the value of its own address, with or without a write, whether the two addresses are equal or different.
- R9: With we_i low, an address match between waddr_i and a read address causes no bypass, and the stored value is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the write takes effect on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all registers |
| we_i | input | 1 | Write enable from writeback |
| waddr_i | input | 5 | Write register index |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Read port A register index |
| rdata_a_o | output | 32 | Read port A data (combinational) |
| raddr_b_i | input | 5 | Read port B register index |
| rdata_b_o | output | 32 | Read port B data (combinational) |

## Verification
The assertions check four things on every cycle. The first is that address 0 reads as zero on both ports. The second is that a qualifying address match forwards wdata_i to each port. The third is that an enabled write to a nonzero register lands in storage by the next cycle. The fourth is that storage stays unchanged when writing is disabled. Only the bench scenarios can show the reset clearing, the absence of a bypass when enable is low, that an ignored x0 write leaves later reads at zero, and that a long random mix of reads and writes matches an independent model.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int unsigned RF_DEPTH = 32;
  localparam int unsigned RF_WIDTH = 32;
  localparam int unsigned RF_NUM_RD = 2;

  typedef enum int unsigned {
    RD_PORT_A = 0,
    RD_PORT_B = 1
  } rd_port_e;
endpackage

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  mem_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;

  // entry 0 is hardwired, no flops
  assign mem_q[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_entry
    logic sel;
    assign sel = we_i && (waddr_i == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[g] <= '0;
      else if (sel) mem_q[g] <= wdata_i;
    end
  end

  assign mem_o = mem_q;

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
module rf_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] mem_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               waddr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [ADDR_W-1:0]               raddr_i,
  output logic [DATA_W-1:0]               rdata_o
);
  logic is_zero;
  logic hit;

  assign is_zero = (raddr_i == '0);
  assign hit     = we_i && (waddr_i == raddr_i);

  always_comb begin
    if (is_zero)  rdata_o = '0;
    else if (hit) rdata_o = wdata_i;
    else          rdata_o = mem_i[raddr_i];
  end
endmodule

// File: rtl/regfile_2r1w.sv
`timescale 1ns/1ps
module regfile_2r1w #(
  parameter int unsigned NUM_REGS = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W   = rf_pkg::RF_WIDTH,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_RD  = rf_pkg::RF_NUM_RD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] mem;
  logic [NUM_RD-1:0][ADDR_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  assign raddr[rf_pkg::RD_PORT_A] = raddr_a_i;
  assign raddr[rf_pkg::RD_PORT_B] = raddr_b_i;
  assign rdata_a_o = rdata[rf_pkg::RD_PORT_A];
  assign rdata_b_o = rdata[rf_pkg::RD_PORT_B];

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_storage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (waddr_i),
    .wdata_i (wdata_i),
    .mem_o   (mem)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_port (
      .mem_i   (mem),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (raddr[p]),
      .rdata_o (rdata[p])
    );
  end

  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));
  a_r4_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));
  a_r6_bypass_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && waddr_i == raddr_a_i) |-> (rdata_a_o == wdata_i));
  a_r7_bypass_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && waddr_i == raddr_b_i) |-> (rdata_b_o == wdata_i));
endmodule

// File: tb/test_regfile_2r1w.sv
`timescale 1ns/1ps
module test_regfile_2r1w;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0, ra = '0, rb = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rda, rdb;

  logic [31:0] model [32];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  regfile_2r1w i_regfile_2r1w (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .rdata_a_o(rda), .raddr_b_i(rb), .rdata_b_o(rdb)
  );

  function automatic logic [31:0] exp_rd(logic [4:0] a, logic w, logic [4:0] wa, logic [31:0] wd);
    if (a == 0) return 32'h0;
    if (w && wa == a) return wd;
    return model[a];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare mid-low phase, commit model at posedge
  task automatic step(string tag, logic w, logic [4:0] wa, logic [31:0] wd,
                      logic [4:0] a, logic [4:0] b);
    @(negedge clk);
    we = w; waddr = wa; wdata = wd; ra = a; rb = b;
    #1;
    check(tag, rda, exp_rd(a, w, wa, wd));
    check(tag, rdb, exp_rd(b, w, wa, wd));
    @(posedge clk);
    if (w && wa != 0) model[wa] = wd;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    clear_model();
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    // R1: all clear after reset
    for (int i = 0; i < 32; i += 2) step("R1", 1'b0, 5'd0, 32'h0, 5'(i), 5'(i + 1));
    // R2: write then read later
    step("R2", 1'b1, 5'd5, 32'hA5A5_0005, 5'd1, 5'd2);
    step("R2", 1'b0, 5'd0, 32'h0, 5'd5, 5'd5);
    // R9: match with enable low, no bypass
    step("R9", 1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5);
    // R3: stored value unchanged after disabled write
    step("R3", 1'b0, 5'd0, 32'h0, 5'd5, 5'd3);
    // R5: write x0, same-cycle read of x0 stays zero
    step("R5", 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R4", 1'b0, 5'd0, 32'h0, 5'd0, 5'd5);
    // R6 / R7: bypass on each port alone and both together
    step("R6", 1'b1, 5'd7, 32'h1234_5677, 5'd7, 5'd5);
    step("R7", 1'b1, 5'd9, 32'h0BAD_F00D, 5'd7, 5'd9);
    step("R6", 1'b1, 5'd31, 32'h8000_0001, 5'd31, 5'd31);
    step("R8", 1'b0, 5'd0, 32'h0, 5'd31, 5'd9);
    // R1: asynchronous reset mid-run
    @(negedge clk);
    we = 1'b0; ra = 5'd7; rb = 5'd31;
    rst_ni = 1'b0;
    #1;
    check("R1", rda, 32'h0);
    check("R1", rdb, 32'h0);
    clear_model();
    @(negedge clk);
    rst_ni = 1'b1;
    step("R1", 1'b0, 5'd0, 32'h0, 5'd9, 5'd5);
    // R8: random mix
    for (int k = 0; k < 3000; k++) begin
      logic w;
      logic [4:0] wa, a, b;
      w  = ($urandom % 4) != 0;
      wa = 5'($urandom % 32);
      a  = ($urandom % 4 == 0) ? wa : 5'($urandom % 32);
      b  = ($urandom % 4 == 0) ? wa : 5'($urandom % 32);
      step("R8", w, wa, $urandom, a, b);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule